// File: doc/BRIEF.md
# Multiplexed DMA Request Scanner

This block gathers seven DMA request lines through an external 4-to-1 selector. The selector presents two request lines at a time. The block drives the selector address. On each oscillator tick it captures the pair on the two selector outputs into a request latch, then moves to the next pair. Four ticks refresh every channel. The latched requests, masked by the per-channel enable bits, go to the DMA arbiter.

When the arbiter grants a channel that is pending, the scan stops on that channel's pair. The channel number is placed on a 3-bit acknowledge code. On the next oscillator tick an active-low decoder enable is asserted, so that an external 3-to-8 decoder can rebuild the individual acknowledge. When the arbiter reports that the transfer is complete, the enable is released. On the next tick the block returns to scanning. Scanning resumes at the pair where it stopped, not at pair zero.

Top module: `dma_req_scanner`

## Requirements
- R1: After reset, `sel_addr` is 0, `req_vec` is all zero, `ack_code` is 0 and `ack_en_n` is 1.
- R2: While scanning, each cycle with `osc_tick` high advances `sel_addr` by one. The sequence is 0,1,2,3 and then wraps to 0.
- R3: A tick at step k stores `sel_in[0]` as channel 2k and `sel_in[1]` as channel 2k+1. At step 3, `sel_in[1]` has no channel and is ignored. Four ticks refresh all seven channels, and several channels can be pending at once.
- R4: `req_vec` is the latched request ANDed with `ch_enable`. The latch of a disabled channel still holds its request. That request appears in `req_vec` as soon as the channel is enabled, with no new scan.
- R5: A grant is accepted only if `grant_ch` names a channel whose `req_vec` bit is set. Any other grant has no effect on `ack_code` or `ack_en_n`.
- R6: On an accepted grant, the next clock edge sets `ack_code` to the channel number and `sel_addr` to channel/2. `ack_en_n` stays high at that point.
- R7: `ack_en_n` goes low at the first `osc_tick` after the grant, so the code is valid before the enable.
- R8: While locked, `sel_addr` and every latched request bit are frozen, whatever the selector outputs show. Further grants are ignored while locked.
- R9: `xfer_done` while the enable is low drives `ack_en_n` high at the next edge. `ack_code` keeps its value until the next accepted grant.
- R10: After the release, the next tick returns the block to scanning without sampling. The following tick samples the locked pair and moves on from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse at the oscillator rate |
| sel_in | input | 2 | The two outputs of the external selector, lane 0 = even channel |
| ch_enable | input | 7 | Per-channel enable bits set by software |
| grant_valid | input | 1 | Arbiter grants `grant_ch` this cycle |
| grant_ch | input | 3 | Channel number being granted |
| xfer_done | input | 1 | Arbiter reports that the granted transfer has ended |
| sel_addr | output | 2 | Address to the external selector |
| req_vec | output | 7 | Enabled latched requests presented to the arbiter |
| ack_code | output | 3 | Encoded acknowledge channel |
| ack_en_n | output | 1 | Active-low enable for the external decoder |

## Verification
The bench builds the block with its defaults of seven channels and two lanes. This gives four scan steps, and the last step carries one real channel beside an unused lane. The bench's selector model drives that unused lane high at all times, so any leak from it into the latch shows up as a wrong vector. The locked case is tested on the last pair (channel 6) as well as a middle pair, so that both the resume point and the wrap after it are covered.

// File: rtl/dma_scan_pkg.sv
package dma_scan_pkg;

  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RELEASE = 2'd3
  } lock_state_e;

  // Scan step that carries a given channel.
  function automatic int step_of(int ch, int lanes);
    return ch / lanes;
  endfunction

  // Selector lane that carries a given channel.
  function automatic int lane_of(int ch, int lanes);
    return ch % lanes;
  endfunction

  // True when channel ch exists and is pending in vec.
  function automatic logic is_pending(logic [31:0] vec, int ch, int n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < n; i++)
      if (i == ch) r = vec[i];
    return r;
  endfunction

endpackage

// File: rtl/scan_step_ctr.sv
module scan_step_ctr #(
  parameter int STEPS = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [SEL_W-1:0] load_val,
  output logic [SEL_W-1:0] step
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)      step <= '0;
    else if (load)   step <= load_val;
    else if (adv)    step <= (step == LAST) ? '0 : step + 1'b1;
  end
endmodule

// File: rtl/req_latch_bank.sv
module req_latch_bank
  import dma_scan_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int LANES  = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [SEL_W-1:0]  step,
  input  logic [LANES-1:0]  lane_in,
  output logic [NUM_CH-1:0] latched
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int STEP = step_of(c, LANES);
    localparam int LANE = lane_of(c, LANES);
    always_ff @(posedge clk) begin
      if (!rst_n)
        latched[c] <= 1'b0;
      else if (sample_en && step == SEL_W'(STEP))
        latched[c] <= lane_in[LANE];
    end
  end
endmodule

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import dma_scan_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              grant_valid,
  input  logic [CH_W-1:0]   grant_ch,
  input  logic              xfer_done,
  input  logic [NUM_CH-1:0] req_vec,
  output logic [CH_W-1:0]   ack_code,
  output logic              ack_en_n,
  output logic              grant_take,
  output logic              scanning,
  output logic              lock_active
);
  lock_state_e state;

  assign scanning    = (state == ST_SCAN);
  assign lock_active = !scanning;
  assign ack_en_n    = (state != ST_ACTIVE);
  assign grant_take  = scanning && grant_valid &&
                       is_pending(32'(req_vec), int'(grant_ch), NUM_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_SCAN;
      ack_code <= '0;
    end else begin
      unique case (state)
        ST_SCAN: if (grant_take) begin
          state    <= ST_SETUP;
          ack_code <= grant_ch;
        end
        ST_SETUP:   if (osc_tick)  state <= ST_ACTIVE;
        ST_ACTIVE:  if (xfer_done) state <= ST_RELEASE;
        ST_RELEASE: if (osc_tick)  state <= ST_SCAN;
        default:                   state <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/dma_req_scanner.sv
module dma_req_scanner
  import dma_scan_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int LANES  = 2,
  localparam int STEPS = (NUM_CH + LANES - 1) / LANES,
  localparam int SEL_W = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [LANES-1:0]  sel_in,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic              grant_valid,
  input  logic [CH_W-1:0]   grant_ch,
  input  logic              xfer_done,
  output logic [SEL_W-1:0]  sel_addr,
  output logic [NUM_CH-1:0] req_vec,
  output logic [CH_W-1:0]   ack_code,
  output logic              ack_en_n
);
  // Named internal events, also used by the bound checker.
  logic              grant_take;
  logic              scanning;
  logic              lock_active;
  logic              sample_en;
  logic [NUM_CH-1:0] req_latched;
  logic [SEL_W-1:0]  lock_step;

  assign sample_en = osc_tick && scanning && !grant_take;
  assign lock_step = SEL_W'(step_of(int'(grant_ch), LANES));
  assign req_vec   = req_latched & ch_enable;

  scan_step_ctr #(.STEPS(STEPS), .SEL_W(SEL_W)) u_step (
    .clk(clk), .rst_n(rst_n), .adv(sample_en), .load(grant_take),
    .load_val(lock_step), .step(sel_addr)
  );

  req_latch_bank #(.NUM_CH(NUM_CH), .LANES(LANES), .SEL_W(SEL_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .step(sel_addr),
    .lane_in(sel_in), .latched(req_latched)
  );

  ack_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .xfer_done(xfer_done), .req_vec(req_vec),
    .ack_code(ack_code), .ack_en_n(ack_en_n), .grant_take(grant_take),
    .scanning(scanning), .lock_active(lock_active)
  );
endmodule

// File: rtl/dma_req_scanner_chk.sv
module dma_req_scanner_chk #(
  parameter int NUM_CH = 7,
  parameter int STEPS  = 4,
  parameter int SEL_W  = 2,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_tick,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [CH_W-1:0]   grant_ch,
  input logic [SEL_W-1:0]  sel_addr,
  input logic [NUM_CH-1:0] req_latched,
  input logic [CH_W-1:0]   ack_code,
  input logic              ack_en_n,
  input logic              grant_take,
  input logic              lock_active
);
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_addr) < STEPS);

  assert_grant_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_take |-> (int'(grant_ch) < NUM_CH) && ch_enable[grant_ch]);

  assert_code_before_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_en_n) |-> $past(osc_tick) && $stable(ack_code));

  assert_frozen_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && $past(lock_active)) |-> $stable(sel_addr) && $stable(req_latched));

  assert_code_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_code) |-> ack_en_n && $past(ack_en_n));
endmodule

bind dma_req_scanner dma_req_scanner_chk #(
  .NUM_CH(NUM_CH), .STEPS(STEPS), .SEL_W(SEL_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ch_enable(ch_enable),
  .grant_ch(grant_ch), .sel_addr(sel_addr), .req_latched(req_latched),
  .ack_code(ack_code), .ack_en_n(ack_en_n), .grant_take(grant_take),
  .lock_active(lock_active)
);

// File: tb/dma_req_scanner_tb.sv
module dma_req_scanner_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [1:0] sel_in;
  logic [6:0] ch_enable = 7'h7F;
  logic       grant_valid = 1'b0;
  logic [2:0] grant_ch = 3'd0;
  logic       xfer_done = 1'b0;
  logic [1:0] sel_addr;
  logic [6:0] req_vec;
  logic [2:0] ack_code;
  logic       ack_en_n;
  logic [6:0] ext_req = '0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // External selector model: unused lane of the last step is tied high.
  logic [7:0] ext8;
  assign ext8   = {1'b1, ext_req};
  assign sel_in = {ext8[2*sel_addr+1], ext8[2*sel_addr]};

  dma_req_scanner u_dut (.*);

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
  endtask

  task automatic grant(input logic [2:0] ch);
    @(negedge clk) begin grant_valid = 1'b1; grant_ch = ch; end
    @(negedge clk) grant_valid = 1'b0;
  endtask

  task automatic finish_xfer();
    @(negedge clk) xfer_done = 1'b1;
    @(negedge clk) xfer_done = 1'b0;
  endtask

  localparam logic [6:0] PAT [6] = '{7'b0000001, 7'b1000000, 7'b1001001,
                                     7'b0110110, 7'b1111111, 7'b0000000};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel_addr", sel_addr, 0);
    chk("R1 req_vec", req_vec, 0);
    chk("R1 ack_code", ack_code, 0);
    chk("R1 ack_en_n", ack_en_n, 1);
    // R2 step sequence
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk("R2 step", sel_addr, i % 4);
    end
    // R3 table of request patterns, several pending at once
    for (int i = 0; i < 6; i++) begin
      ext_req = PAT[i];
      repeat (4) tick();
      chk("R3 latched pattern", req_vec, PAT[i]);
    end
    // R5 grant of a channel that is not pending is ignored
    grant(3'd3);
    tick();
    chk("R5 no-pend en", ack_en_n, 1);
    chk("R5 no-pend code", ack_code, 0);
    // R6/R7 grant channel 5
    ext_req = 7'b0100000;
    repeat (4) tick();
    grant(3'd5);
    chk("R6 code", ack_code, 5);
    chk("R6 pair", sel_addr, 2);
    chk("R6 en still high", ack_en_n, 1);
    tick();
    chk("R7 en low", ack_en_n, 0);
    // R8 frozen, new grants ignored
    ext_req = 7'b0100001;
    repeat (3) tick();
    grant(3'd0);
    chk("R8 sel frozen", sel_addr, 2);
    chk("R8 latch frozen", req_vec, 7'b0100000);
    chk("R8 grant ignored", ack_code, 5);
    // R9 release
    ext_req = 7'b0000000;
    finish_xfer();
    chk("R9 en high", ack_en_n, 1);
    chk("R9 code held", ack_code, 5);
    // R10 resume at the lock point
    tick();
    chk("R10 no sample", sel_addr, 2);
    chk("R10 bit held", req_vec, 7'b0100000);
    tick();
    chk("R10 resume step", sel_addr, 3);
    chk("R10 refreshed", req_vec, 0);
    // R4 disabled channel latched but hidden
    ch_enable = 7'b1111101;
    ext_req   = 7'b0000010;
    repeat (4) tick();
    chk("R4 hidden", req_vec, 0);
    grant(3'd1);
    tick();
    chk("R4 disabled not granted", ack_en_n, 1);
    chk("R4 code unchanged", ack_code, 5);
    ch_enable = 7'h7F;
    @(negedge clk);
    chk("R4 appears on enable", req_vec, 7'b0000010);
    ext_req = 7'b0000000;
    repeat (4) tick();
    // Lock on the last pair, channel 6, and resume with wrap
    ext_req = 7'b1000000;
    repeat (4) tick();
    grant(3'd6);
    chk("R6 code ch6", ack_code, 6);
    chk("R6 pair ch6", sel_addr, 3);
    tick();
    chk("R7 en low ch6", ack_en_n, 0);
    ext_req = 7'b0000000;
    finish_xfer();
    tick();
    tick();
    chk("R10 wrap after lock", sel_addr, 0);
    chk("R3 masked lane", req_vec, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule